// File: doc/BRIEF.md
# Converter Command Control Register

This block holds the command word that software uses to drive an analog-to-digital converter core. There are five command bits: enable, disable, start, stop and calibrate. Software can only set them. The block clears each one itself when the converter core reports that the matching operation has finished. A sixth bit, regulator enable, is an ordinary read/write bit. The block drives all six bits to the core as steady levels.

Each software set is accepted only when the register is in a legal state, and any other write has no effect. When the start bit clears depends on the conversion mode inputs (continuous, discontinuous) and on the trigger select. A change to the channel configuration blocks new starts until the core reports that the new configuration is ready.

Top module: `conv_cmd_reg`

## Requirements
- R1: Enable is at bit 0, disable at bit 1, start at bit 2, stop at bit 4, regulator enable at bit 28 and calibrate at bit 31. The read value and the six output levels show the stored bits. After reset every bit is 0.
- R2: Writing 0 to any of the five command bits leaves that bit unchanged. Regulator enable takes the written value whenever a write to it is accepted.
- R3: A write with bit 0 set sets enable only if enable, disable, start, stop and calibrate are all 0.
- R4: A write with bit 1 set sets disable only if enable is 1 and start is 0. A disable-done pulse while disable is 1 clears disable and enable in the same cycle.
- R5: A write with bit 2 set sets start only if enable is 1 and disable is 0. It is also ignored after a channel-configuration change pulse, until a config-ready pulse has been seen.
- R6: With continuous=0 and trigger select 00, start clears on an end-of-sequence pulse when discontinuous=0, and on an end-of-conversion pulse when discontinuous=1. The other pulse of the two leaves start set.
- R7: In every other mode (continuous=1, or trigger select other than 00), end-of-conversion and end-of-sequence leave start set. Start clears only when a stop completes, in the same cycle as stop.
- R8: A write with bit 4 set sets stop only if start is 1 and disable is 0. A stop-done pulse while stop is 1 clears stop and start.
- R9: A write with bit 31 set sets calibrate only if all five command bits are 0. A calibration-done pulse while calibrate is 1 clears it.
- R10: A write changes regulator enable only if all five command bits are 0. It can therefore never be cleared while enable is 1.
- R11: Written values in bits other than the six listed have no effect, and those bits always read 0.
- R12: When a hardware clear and a software set hit the same bit in the same cycle, the bit ends up 0.
- R13: A write from the all-zero command state that sets both bit 0 and bit 31 starts calibration only. Enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register value |
| cfg_change_i | input | 1 | Pulse: channel configuration was changed |
| cfg_ready_i | input | 1 | Pulse: core has taken the new channel configuration |
| eoc_i | input | 1 | Pulse: end of one conversion |
| eos_i | input | 1 | Pulse: end of a conversion sequence |
| cal_done_i | input | 1 | Pulse: calibration finished |
| dis_done_i | input | 1 | Pulse: converter is now off |
| stop_done_i | input | 1 | Pulse: ongoing conversion discarded |
| cont_i | input | 1 | Continuous conversion mode |
| disc_i | input | 1 | Discontinuous conversion mode |
| trig_sel_i | input | 2 | Trigger edge select; 00 means software trigger |
| en_o | output | 1 | Enable level to the core |
| dis_o | output | 1 | Disable request level |
| start_o | output | 1 | Start level |
| stop_o | output | 1 | Stop request level |
| cal_o | output | 1 | Calibrate level |
| vreg_o | output | 1 | Regulator enable level |

## Verification
The hardest case to reach is a stop-done pulse arriving in the same cycle as a fresh software write of start. That needs a hardware-trigger mode, in which only a stop clears start, and a stop that is already pending when the write lands. The stimulus table builds this up over several rows. It selects a hardware trigger, shows that end-of-sequence leaves start set, and writes stop. Only then does it issue the start write together with the stop-done pulse. The blocked-start window after a configuration change is reached the same way: the change pulse, the refused start and the ready pulse each get their own row.

// File: rtl/conv_cmd_pkg.sv
package conv_cmd_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned POS_EN    = 0;
    localparam int unsigned POS_DIS   = 1;
    localparam int unsigned POS_START = 2;
    localparam int unsigned POS_STOP  = 4;
    localparam int unsigned POS_VREG  = 28;
    localparam int unsigned POS_CAL   = 31;
    localparam int unsigned TRIG_W    = 2;

    typedef struct packed {
        logic en;
        logic dis;
        logic start;
        logic stop;
        logic cal;
        logic vreg;
    } cmd_state_t;

    typedef struct packed {
        logic en;
        logic dis;
        logic start;
        logic stop;
        logic cal;
        logic vreg_wr;
    } cmd_set_t;

    typedef struct packed {
        logic en;
        logic dis;
        logic start;
        logic stop;
        logic cal;
    } cmd_clr_t;

    typedef struct packed {
        logic eoc;
        logic eos;
        logic cal_done;
        logic dis_done;
        logic stop_done;
    } core_evt_t;

    function automatic logic cmd_idle(cmd_state_t s);
        return !(s.en || s.dis || s.start || s.stop || s.cal);
    endfunction

endpackage

// File: rtl/conv_cfg_guard.sv
module conv_cfg_guard (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cfg_change_i,
    input  logic cfg_ready_i,
    output logic pending_o
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (cfg_ready_i)  pend_d = 1'b0;
        if (cfg_change_i) pend_d = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= pend_d;
    end

    assign pending_o = pend_q;

endmodule

// File: rtl/conv_cmd_accept.sv
module conv_cmd_accept
    import conv_cmd_pkg::*;
#(
    parameter int unsigned DW = REG_W
) (
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  cmd_state_t    state_i,
    input  logic          cfg_pending_i,
    output cmd_set_t      set_o
);

    logic idle;

    always_comb begin
        idle          = cmd_idle(state_i);
        set_o         = '0;
        set_o.cal     = wr_en_i && wr_data_i[POS_CAL] && idle;
        set_o.en      = wr_en_i && wr_data_i[POS_EN] && idle && !wr_data_i[POS_CAL];
        set_o.dis     = wr_en_i && wr_data_i[POS_DIS] && state_i.en && !state_i.start;
        set_o.start   = wr_en_i && wr_data_i[POS_START] && state_i.en && !state_i.dis
                        && !cfg_pending_i;
        set_o.stop    = wr_en_i && wr_data_i[POS_STOP] && state_i.start && !state_i.dis;
        set_o.vreg_wr = wr_en_i && idle;
    end

endmodule

// File: rtl/conv_cmd_clear.sv
module conv_cmd_clear
    import conv_cmd_pkg::*;
#(
    parameter int unsigned TW = TRIG_W
) (
    input  cmd_state_t    state_i,
    input  core_evt_t     evt_i,
    input  logic          cont_i,
    input  logic          disc_i,
    input  logic [TW-1:0] trig_sel_i,
    output cmd_clr_t      clr_o
);

    logic sw_single;
    logic seq_end;

    always_comb begin
        sw_single   = (trig_sel_i == '0) && !cont_i;
        seq_end     = disc_i ? evt_i.eoc : evt_i.eos;
        clr_o       = '0;
        clr_o.cal   = state_i.cal  && evt_i.cal_done;
        clr_o.dis   = state_i.dis  && evt_i.dis_done;
        clr_o.en    = clr_o.dis;
        clr_o.stop  = state_i.stop && evt_i.stop_done;
        clr_o.start = clr_o.stop || (state_i.start && sw_single && seq_end);
    end

endmodule

// File: rtl/conv_cmd_reg.sv
module conv_cmd_reg
    import conv_cmd_pkg::*;
#(
    parameter int unsigned DW = REG_W,
    parameter int unsigned TW = TRIG_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          cfg_change_i,
    input  logic          cfg_ready_i,
    input  logic          eoc_i,
    input  logic          eos_i,
    input  logic          cal_done_i,
    input  logic          dis_done_i,
    input  logic          stop_done_i,
    input  logic          cont_i,
    input  logic          disc_i,
    input  logic [TW-1:0] trig_sel_i,
    output logic          en_o,
    output logic          dis_o,
    output logic          start_o,
    output logic          stop_o,
    output logic          cal_o,
    output logic          vreg_o
);

    cmd_state_t st_d, st_q;
    cmd_set_t   set_req;
    cmd_clr_t   clr_req;
    core_evt_t  evt;
    logic       cfg_pending;

    assign evt = '{eoc: eoc_i, eos: eos_i, cal_done: cal_done_i,
                   dis_done: dis_done_i, stop_done: stop_done_i};

    conv_cfg_guard u_guard (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cfg_change_i (cfg_change_i),
        .cfg_ready_i  (cfg_ready_i),
        .pending_o    (cfg_pending)
    );

    conv_cmd_accept #(.DW(DW)) u_accept (
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .state_i       (st_q),
        .cfg_pending_i (cfg_pending),
        .set_o         (set_req)
    );

    conv_cmd_clear #(.TW(TW)) u_clear (
        .state_i    (st_q),
        .evt_i      (evt),
        .cont_i     (cont_i),
        .disc_i     (disc_i),
        .trig_sel_i (trig_sel_i),
        .clr_o      (clr_req)
    );

    // Sets first, clears last: a clear wins over a set on the same bit.
    always_comb begin
        st_d = st_q;
        if (set_req.en)      st_d.en    = 1'b1;
        if (set_req.dis)     st_d.dis   = 1'b1;
        if (set_req.start)   st_d.start = 1'b1;
        if (set_req.stop)    st_d.stop  = 1'b1;
        if (set_req.cal)     st_d.cal   = 1'b1;
        if (set_req.vreg_wr) st_d.vreg  = wr_data_i[POS_VREG];
        if (clr_req.en)      st_d.en    = 1'b0;
        if (clr_req.dis)     st_d.dis   = 1'b0;
        if (clr_req.start)   st_d.start = 1'b0;
        if (clr_req.stop)    st_d.stop  = 1'b0;
        if (clr_req.cal)     st_d.cal   = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rd_data_o            = '0;
        rd_data_o[POS_EN]    = st_q.en;
        rd_data_o[POS_DIS]   = st_q.dis;
        rd_data_o[POS_START] = st_q.start;
        rd_data_o[POS_STOP]  = st_q.stop;
        rd_data_o[POS_VREG]  = st_q.vreg;
        rd_data_o[POS_CAL]   = st_q.cal;
    end

    assign en_o    = st_q.en;
    assign dis_o   = st_q.dis;
    assign start_o = st_q.start;
    assign stop_o  = st_q.stop;
    assign cal_o   = st_q.cal;
    assign vreg_o  = st_q.vreg;

    assert_en_from_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.en) |-> $past(!st_q.dis && !st_q.start && !st_q.stop && !st_q.cal));

    assert_dis_clears_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.dis) |-> $fell(st_q.en));

    assert_start_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.start) |-> $past(st_q.en && !st_q.dis && !cfg_pending));

    assert_stop_clears_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.stop) |-> !st_q.start);

    assert_cal_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cal_done_i && st_q.cal) |=> !st_q.cal);

    assert_vreg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.vreg) |-> $past(!st_q.en));

    assert_en_cal_exclusive_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(st_q.en && st_q.cal));

endmodule

// File: tb/conv_cmd_reg_tb_top.sv
`timescale 1ns/1ps
module conv_cmd_reg_tb_top;

    localparam logic [6:0] E_NONE = 7'h00, E_CHG = 7'h40, E_RDY = 7'h20, E_EOC = 7'h10,
                           E_EOS = 7'h08, E_CALD = 7'h04, E_DISD = 7'h02, E_STPD = 7'h01;
    localparam logic [3:0] M_SW = 4'b0000, M_DISC = 4'b0100, M_CONT = 4'b1000, M_HW = 4'b0001;
    localparam int NV = 31;
    // {wr, data, events, mode{cont,disc,trig}, expected read, requirement}
    localparam logic [83:0] VEC [NV] = '{
        {1'b1, 32'h1000_0000, E_NONE, M_SW,   32'h1000_0000, 8'd10}, // R10
        {1'b1, 32'h9000_0000, E_NONE, M_SW,   32'h9000_0000, 8'd9},  // R9
        {1'b1, 32'h0000_0001, E_NONE, M_SW,   32'h9000_0000, 8'd3},  // R3
        {1'b0, 32'h0,         E_CALD, M_SW,   32'h1000_0000, 8'd9},  // R9
        {1'b1, 32'h1000_0001, E_NONE, M_SW,   32'h1000_0001, 8'd3},  // R3
        {1'b1, 32'h0000_0000, E_NONE, M_SW,   32'h1000_0001, 8'd2},  // R2
        {1'b1, 32'h1000_0004, E_NONE, M_SW,   32'h1000_0005, 8'd5},  // R5
        {1'b0, 32'h0,         E_EOC,  M_SW,   32'h1000_0005, 8'd6},  // R6
        {1'b0, 32'h0,         E_EOS,  M_SW,   32'h1000_0001, 8'd6},  // R6
        {1'b1, 32'h0000_0004, E_NONE, M_DISC, 32'h1000_0005, 8'd5},  // R5
        {1'b0, 32'h0,         E_EOC,  M_DISC, 32'h1000_0001, 8'd6},  // R6
        {1'b1, 32'h0000_0004, E_NONE, M_CONT, 32'h1000_0005, 8'd5},  // R5
        {1'b0, 32'h0,         E_EOS,  M_CONT, 32'h1000_0005, 8'd7},  // R7
        {1'b1, 32'h0000_0002, E_NONE, M_CONT, 32'h1000_0005, 8'd4},  // R4
        {1'b1, 32'h0000_0010, E_NONE, M_CONT, 32'h1000_0015, 8'd8},  // R8
        {1'b0, 32'h0,         E_STPD, M_CONT, 32'h1000_0001, 8'd7},  // R7
        {1'b1, 32'h0000_0010, E_NONE, M_SW,   32'h1000_0001, 8'd8},  // R8
        {1'b0, 32'h0,         E_CHG,  M_SW,   32'h1000_0001, 8'd5},  // R5
        {1'b1, 32'h0000_0004, E_NONE, M_SW,   32'h1000_0001, 8'd5},  // R5
        {1'b0, 32'h0,         E_RDY,  M_SW,   32'h1000_0001, 8'd5},  // R5
        {1'b1, 32'h0000_0004, E_NONE, M_HW,   32'h1000_0005, 8'd5},  // R5
        {1'b0, 32'h0,         E_EOS,  M_HW,   32'h1000_0005, 8'd7},  // R7
        {1'b1, 32'h0000_0010, E_NONE, M_HW,   32'h1000_0015, 8'd8},  // R8
        {1'b1, 32'h0000_0004, E_STPD, M_HW,   32'h1000_0001, 8'd12}, // R12
        {1'b1, 32'h0000_0002, E_NONE, M_SW,   32'h1000_0003, 8'd4},  // R4
        {1'b1, 32'h0000_0004, E_NONE, M_SW,   32'h1000_0003, 8'd5},  // R5
        {1'b1, 32'h0000_0F08, E_NONE, M_SW,   32'h1000_0003, 8'd11}, // R11
        {1'b0, 32'h0,         E_DISD, M_SW,   32'h1000_0000, 8'd4},  // R4
        {1'b1, 32'h9000_0001, E_NONE, M_SW,   32'h9000_0000, 8'd13}, // R13
        {1'b0, 32'h0,         E_CALD, M_SW,   32'h1000_0000, 8'd9},  // R9
        {1'b1, 32'h0000_0000, E_NONE, M_SW,   32'h0000_0000, 8'd10}  // R10
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0, rd_data;
    logic [6:0] ev = '0;
    logic [3:0] mode = '0;
    logic en, dis, start, stop, cal, vreg;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    conv_cmd_reg dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .cfg_change_i(ev[6]), .cfg_ready_i(ev[5]),
        .eoc_i(ev[4]), .eos_i(ev[3]), .cal_done_i(ev[2]), .dis_done_i(ev[1]),
        .stop_done_i(ev[0]), .cont_i(mode[3]), .disc_i(mode[2]), .trig_sel_i(mode[1:0]),
        .en_o(en), .dis_o(dis), .start_o(start), .stop_o(stop), .cal_o(cal), .vreg_o(vreg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [31:0] d, input logic [6:0] e,
                        input logic [3:0] m);
        @(negedge clk);
        wr_en = w; wr_data = d; ev = e; mode = m;
        @(posedge clk);
        #1;
        wr_en = 1'b0; ev = '0;
    endtask

    function automatic logic [31:0] outs();
        return {cal, 2'b00, vreg, 23'd0, stop, 1'b0, start, dis, en};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state on read port and levels
        check("R1", rd_data, 32'h0);
        check("R1", outs(), 32'h0);
        for (int i = 0; i < NV; i++) begin
            logic [83:0] v;
            v = VEC[i];
            step(v[83], v[82:51], v[50:44], v[43:40]);
            check($sformatf("R%0d", v[7:0]), rd_data, v[39:8]);
        end
        // R1: output levels track register bits
        step(1'b1, 32'h1000_0000, E_NONE, M_SW);
        step(1'b1, 32'h1000_0001, E_NONE, M_SW);
        step(1'b1, 32'h0000_0004, E_NONE, M_HW);
        step(1'b1, 32'h0000_0010, E_NONE, M_HW);
        check("R1", outs(), 32'h1000_0015);
        check("R1", rd_data, 32'h1000_0015);
        // R1: reset mid-run returns everything to zero
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", rd_data, 32'h0);
        check("R1", outs(), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule